// File: doc/BRIEF.md
# Interrupt Priority Resolver with End-of-Interrupt Handling

This block takes eight interrupt request lines and keeps three 8-bit registers: pending requests, mask and in-service. Each cycle it picks the highest-priority request that is pending, not masked and not held back by a level already in service. It reports that level on `sel_lvl` with `sel_valid`, and it raises `irq_out` while a level is selected.

A controller around the block supplies three things: the trigger mode, the mask byte, and command strobes that have already been decoded. An `ack` strobe moves the selected level from pending to in-service. End-of-interrupt commands clear in-service bits, either the highest-priority one or a named one. Rotation commands move the lowest-priority pointer, which changes the circular priority order. Special mask mode lets lower-priority requests through while a masked level is still in service.

Top module: `irq_prio_resolver`

## Requirements
- R1: With the lowest-priority pointer at 7 (its reset value), level 0 wins over every other level and level 7 loses to every other level. For any pointer value P, priority descends in the order P+1, P+2, … wrapping modulo 8, ending at P.
- R2: With `level_mode`=0 (edge mode), a rising edge on a line, after a one-stage synchronizer, sets its pending bit, and the bit stays set after the line falls. With `level_mode`=1, the pending register copies the request lines each cycle.
- R3: An `ack` while `sel_valid` is high sets the in-service bit of `sel_lvl` and clears its pending bit in the same cycle. While that level is in service, lower-priority requests are not selected, but higher-priority requests are.
- R4: `cmd` is {R,SL,EOI}. Code 001 clears the highest-priority in-service bit under the current priority order. Code 011 clears the in-service bit named by `cmd_lvl`.
- R5: Code 101 clears the highest-priority in-service bit and makes that level the lowest priority. Code 111 clears bit `cmd_lvl` and makes it the lowest priority. Code 110 only sets the lowest-priority pointer to `cmd_lvl`. Code 100 turns auto-rotate on and code 000 turns it off. With auto-rotate on and `auto_eoi`=1, an `ack_end` clears the last acknowledged level and makes it the lowest priority.
- R6: With `special_mask`=1, an in-service level whose mask bit is set does not block lower-priority requests. An in-service level is never itself selected.
- R7: `mask_we` loads `mask_in`. A set mask bit keeps the matching level from being selected.
- R8: Code 010 changes no in-service bit and no priority.
- R9: A synchronous active-high `rst` clears the pending, in-service and mask registers, turns auto-rotate off and puts the lowest-priority pointer back at 7. `irq_out` always equals `sel_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq | input | 8 | Request lines |
| level_mode | input | 1 | 1 = level trigger, 0 = edge trigger |
| mask_we | input | 1 | Load strobe for the mask register |
| mask_in | input | 8 | New mask value |
| cmd_we | input | 1 | Command strobe |
| cmd | input | 3 | Command code {R,SL,EOI} |
| cmd_lvl | input | 3 | Level operand for specific commands |
| special_mask | input | 1 | Special mask mode enable |
| auto_eoi | input | 1 | Automatic EOI at `ack_end` |
| ack | input | 1 | Acknowledge: move the selected level to in-service |
| ack_end | input | 1 | End of the acknowledge sequence |
| irq_out | output | 1 | Interrupt output |
| sel_lvl | output | 3 | Selected level |
| sel_valid | output | 1 | A level is selected |
| irr | output | 8 | Pending-request register |
| isr | output | 8 | In-service register |

## Verification
The assertions run on every cycle and cover four properties. The selected level is always pending and never already in service. An acknowledge lands its level in the in-service register. A specific EOI clears the named bit. Reset and mask loads take effect on the following cycle. Only the bench scenarios can show the priority order after each kind of rotation, the preemption and blocking rules around in-service levels with and without special mask mode, edge-versus-level capture, and the no-op command.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N = 8,
  localparam int LW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq,
  input  logic          level_mode,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_in,
  input  logic          cmd_we,
  input  logic [2:0]    cmd,
  input  logic [LW-1:0] cmd_lvl,
  input  logic          special_mask,
  input  logic          auto_eoi,
  input  logic          ack,
  input  logic          ack_end,
  output logic          irq_out,
  output logic [LW-1:0] sel_lvl,
  output logic          sel_valid,
  output logic [N-1:0]  irr,
  output logic [N-1:0]  isr
);

  logic [N-1:0]  ir_s, ir_d, irr_q, isr_q, mask_q;
  logic [LW-1:0] lp_q, last_q;
  logic          rot_q;

  logic [N-1:0]  pend, blk;
  logic [LW-1:0] top_lvl;
  logic          top_valid;

  assign pend = irr_q & ~mask_q;
  assign blk  = special_mask ? (isr_q & ~mask_q) : isr_q;

  always_comb begin
    logic done;
    sel_lvl   = '0;
    sel_valid = 1'b0;
    top_lvl   = '0;
    top_valid = 1'b0;
    done      = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic [LW-1:0] l;
      l = lp_q + LW'(k + 1);
      if (!top_valid && isr_q[l]) begin
        top_lvl   = l;
        top_valid = 1'b1;
      end
      if (!done) begin
        if (blk[l]) done = 1'b1;
        else if (pend[l]) begin
          sel_lvl   = l;
          sel_valid = 1'b1;
          done      = 1'b1;
        end
      end
    end
  end

  assign irq_out = sel_valid;
  assign irr     = irr_q;
  assign isr     = isr_q;

  logic          take;
  logic [N-1:0]  irr_clr, isr_set, isr_clr, edge_hit;

  assign take     = ack && sel_valid;
  assign edge_hit = ir_s & ~ir_d;
  assign irr_clr  = take ? (N'(1) << sel_lvl) : '0;
  assign isr_set  = take ? (N'(1) << sel_lvl) : '0;

  always_comb begin
    isr_clr = '0;
    if (cmd_we) begin
      case (cmd)
        3'b001, 3'b101: if (top_valid) isr_clr = N'(1) << top_lvl;
        3'b011, 3'b111: isr_clr = N'(1) << cmd_lvl;
        default: ;
      endcase
    end
    if (ack_end && auto_eoi) isr_clr = isr_clr | (N'(1) << last_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_s   <= '0;
      ir_d   <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '0;
      lp_q   <= LW'(N - 1);
      last_q <= '0;
      rot_q  <= 1'b0;
    end else begin
      ir_s  <= irq;
      ir_d  <= ir_s;
      irr_q <= level_mode ? (irq & ~irr_clr) : ((irr_q | edge_hit) & ~irr_clr);
      isr_q <= (isr_q & ~isr_clr) | isr_set;
      if (take) last_q <= sel_lvl;
      if (mask_we) mask_q <= mask_in;
      if (cmd_we) begin
        case (cmd)
          3'b100: rot_q <= 1'b1;
          3'b000: rot_q <= 1'b0;
          3'b101: if (top_valid) lp_q <= top_lvl;
          3'b111, 3'b110: lp_q <= cmd_lvl;
          default: ;
        endcase
      end
      if (ack_end && auto_eoi && rot_q) lp_q <= last_q;
    end
  end

  assert_reset_clears_R9: assert property (@(posedge clk)
    rst |=> (isr_q == '0 && irr_q == '0 && mask_q == '0));

  assert_sel_pending_R7: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> (irr_q[sel_lvl] && !mask_q[sel_lvl]));

  assert_sel_not_in_service_R6: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> !isr_q[sel_lvl]);

  assert_ack_sets_isr_R3: assert property (@(posedge clk) disable iff (rst)
    (ack && sel_valid) |=> isr_q[$past(sel_lvl)]);

  assert_spec_eoi_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && cmd == 3'b011 && !ack) |=> !isr_q[$past(cmd_lvl)]);

  assert_mask_load_R7: assert property (@(posedge clk) disable iff (rst)
    mask_we |=> mask_q == $past(mask_in));

endmodule

// File: tb/irq_prio_resolver_bench.sv
`timescale 1ns/1ps
module irq_prio_resolver_bench;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic       rst, level_mode, mask_we, cmd_we, special_mask, auto_eoi, ack, ack_end;
  logic [7:0] irq, mask_in;
  logic [2:0] cmd, cmd_lvl;
  logic       irq_out, sel_valid;
  logic [2:0] sel_lvl;
  logic [7:0] irr, isr;

  irq_prio_resolver u_irq_prio_resolver (
    .clk, .rst, .irq, .level_mode, .mask_we, .mask_in, .cmd_we, .cmd, .cmd_lvl,
    .special_mask, .auto_eoi, .ack, .ack_end, .irq_out, .sel_lvl, .sel_valid,
    .irr, .isr);

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1; irq = 0; level_mode = 1; mask_we = 0; mask_in = 0; cmd_we = 0;
    cmd = 0; cmd_lvl = 0; special_mask = 0; auto_eoi = 0; ack = 0; ack_end = 0;
    tick(2);
    rst = 0;
    tick();
  endtask

  task automatic command(logic [2:0] c, logic [2:0] l);
    cmd_we = 1; cmd = c; cmd_lvl = l; tick(); cmd_we = 0;
  endtask

  task automatic set_mask(logic [7:0] m);
    mask_we = 1; mask_in = m; tick(); mask_we = 0;
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  // {irq, mask, pointer, exp_valid, exp_lvl}
  localparam logic [22:0] VEC [8] = '{
    {8'h00, 8'h00, 3'd7, 1'b0, 3'd0},
    {8'h94, 8'h00, 3'd7, 1'b1, 3'd2},
    {8'h80, 8'h00, 3'd7, 1'b1, 3'd7},
    {8'h94, 8'h04, 3'd7, 1'b1, 3'd4},
    {8'h03, 8'h00, 3'd0, 1'b1, 3'd1},
    {8'h21, 8'h00, 3'd3, 1'b1, 3'd5},
    {8'h07, 8'h00, 3'd1, 1'b1, 3'd2},
    {8'hFF, 8'hFF, 3'd7, 1'b0, 3'd0}
  };

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    chk("R9 reset isr", isr, 8'h00);
    chk("R9 reset irr", irr, 8'h00);
    chk("R9 reset irq_out", {7'd0, irq_out}, 8'h00);

    // R1 R7 table: priority order and masking
    for (int i = 0; i < 8; i++) begin
      do_reset();
      set_mask(VEC[i][14:7]);
      command(3'b110, VEC[i][6:4]);
      irq = VEC[i][22:15];
      tick(2);
      chk("R1/R7 table valid", {7'd0, sel_valid}, {7'd0, VEC[i][3]});
      chk("R9 irq_out follows valid", {7'd0, irq_out}, {7'd0, VEC[i][3]});
      if (VEC[i][3]) chk("R1/R7 table level", {5'd0, sel_lvl}, {5'd0, VEC[i][2:0]});
    end

    // R2 edge vs level
    do_reset();
    level_mode = 0; irq = 8'h08; tick(3);
    chk("R2 edge sets irr", irr, 8'h08);
    irq = 8'h00; tick(2);
    chk("R2 edge held", irr, 8'h08);
    do_reset();
    level_mode = 1; irq = 8'h08; tick(2);
    chk("R2 level follows", irr, 8'h08);
    irq = 8'h00; tick(2);
    chk("R2 level drops", irr, 8'h00);

    // R3 ack, nesting
    do_reset();
    level_mode = 0; irq = 8'h28; tick(3);
    chk("R3 sel before ack", {5'd0, sel_lvl}, 8'd3);
    do_ack();
    chk("R3 isr set", isr, 8'h08);
    chk("R3 irr cleared", irr, 8'h20);
    chk("R3 lower blocked", {7'd0, sel_valid}, 8'd0);
    irq = 8'h2A; tick(3);
    chk("R3 higher preempts", {sel_valid, 4'd0, sel_lvl}, 8'h81);
    do_ack();
    chk("R3 nested isr", isr, 8'h0A);

    // R8 nop
    command(3'b010, 3'd3);
    chk("R8 nop isr", isr, 8'h0A);

    // R4 EOIs
    command(3'b001, 3'd0);
    chk("R4 nonspecific eoi", isr, 8'h08);
    command(3'b011, 3'd3);
    chk("R4 specific eoi", isr, 8'h00);
    chk("R4 lower now selected", {sel_valid, 4'd0, sel_lvl}, 8'h85);

    // R6 special mask
    do_reset();
    irq = 8'h44; tick(2);
    do_ack();
    chk("R6 blocked without smm", {7'd0, sel_valid}, 8'd0);
    set_mask(8'h04); special_mask = 1; tick();
    chk("R6 smm lets lower through", {sel_valid, 4'd0, sel_lvl}, 8'h86);
    special_mask = 0; tick();
    chk("R6 smm off blocks again", {7'd0, sel_valid}, 8'd0);

    // R5 rotations
    do_reset();
    irq = 8'h11; tick(2);
    command(3'b100, 3'd0);
    auto_eoi = 1;
    chk("R5 before rotate", {5'd0, sel_lvl}, 8'd0);
    do_ack();
    ack_end = 1; tick(); ack_end = 0; tick();
    chk("R5 auto eoi clears", isr, 8'h00);
    chk("R5 auto rotate", {sel_valid, 4'd0, sel_lvl}, 8'h84);
    auto_eoi = 0;
    do_ack();
    command(3'b101, 3'd0);
    tick();
    chk("R5 rotate nonspecific", {sel_valid, 4'd0, sel_lvl}, 8'h80);
    do_ack();
    chk("R5 isr bit0", isr, 8'h01);
    command(3'b111, 3'd0);
    tick();
    chk("R5 rotate specific isr", isr, 8'h00);
    chk("R5 rotate specific order", {sel_valid, 4'd0, sel_lvl}, 8'h84);
    command(3'b000, 3'd0);
    auto_eoi = 1;
    do_ack();
    ack_end = 1; tick(); ack_end = 0; tick();
    chk("R5 auto-rotate off keeps order", {sel_valid, 4'd0, sel_lvl}, 8'h84);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule